// File: doc/BRIEF.md
# GPIO Port Register Block

An eight-bit general-purpose I/O port for a small microcontroller. Three registers sit on a simple register bus: the output latch, the input-mode register (analog or digital for each pin) and the output-mode register (push-pull or open-drain for each pin). The bus has an address, a byte write strobe, a read strobe and a read-modify-write qualifier. A separate single-bit strobe sets or clears one latch bit.

For each pin the block drives a drive-enable, a drive value and a weak pull-up control towards an external pad cell. Pin levels come back through a two-flop synchronizer. A per-pin override mask, with its own drive-enable and value inputs, lets another function take over a pin's driver while the latch keeps its contents.

Register addresses: 0 = output latch, 1 = input mode, 2 = output mode. Address 3 is unused.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset the latch reads 0xFF, the input-mode register reads 0xFF and the output-mode register reads 0x00. With no override, every pad_oe bit is then 0.
- R2: A byte write (bus_we) to address 0, 1 or 2 stores bus_wdata in that register at the next clock edge. Without a write, the latch keeps its value.
- R3: A read of address 0 with bus_rmw low returns the synchronized pin levels. A pin change is visible after two clock edges and not after one.
- R4: A read of address 0 with bus_rmw high returns the latch contents, not the pins.
- R5: A pin whose input-mode bit is 0 (analog) reads as 0 on a pin read. Its pad_oe and pad_pu are both 0.
- R6: For a digital pin without override:
  - a latch bit of 0 gives pad_oe=1 and pad_out=0;
  - a latch bit of 1 gives pad_oe=1 and pad_out=1 when its output-mode bit is 1;
  - a latch bit of 1 with an output-mode bit of 0 gives pad_oe=0.
- R7: bus_bit_we writes bus_bit_val into latch bit bus_bit_sel and leaves the other bits as they were. A byte write to address 0 in the same cycle takes priority.
- R8: pad_pu is 1 only when the pin is digital, pull_en is 1 and the pin is not being driven low.
- R9: When an ovr_mask bit is 1, pad_oe and pad_out for that pin come from ovr_oe and ovr_out (still subject to R5). Writes still update the latch, and the updated value shows on a read-modify-write read.
- R10: Reads of address 1 and 2 return the input-mode and output-mode registers. Address 3 reads 0. rd_data is 0 whenever bus_re is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Byte write data |
| bus_we | input | 1 | Byte write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rmw | input | 1 | Read is part of a read-modify-write |
| bus_bit_we | input | 1 | Single latch bit write strobe |
| bus_bit_sel | input | 3 | Latch bit index for bus_bit_we |
| bus_bit_val | input | 1 | Value for the selected latch bit |
| rd_data | output | 8 | Read data (combinational) |
| pull_en | input | 1 | Global weak pull-up enable |
| ovr_mask | input | 8 | Per-pin override select |
| ovr_oe | input | 8 | Override drive enable |
| ovr_out | input | 8 | Override drive value |
| pin_in | input | 8 | Asynchronous pin levels |
| pad_oe | output | 8 | Pad drive enable |
| pad_out | output | 8 | Pad drive value |
| pad_pu | output | 8 | Pad weak pull-up enable |

## Verification
The hardest case to reach is the split between latch and pins on address 0. The pins must be set to a pattern that differs from the latch, so that a plain read and a read-modify-write read of the same address give different values. The bench also combines an override with a latch write and then reads the latch back through a read-modify-write. This shows that the latch was updated even though the pads never showed the new value. Pin-read latency is checked by sampling after one clock edge and again after two, and analog masking is checked with a pin pattern that has ones in the analog positions.

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int W = 8,
  localparam int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic [W-1:0]  bus_wdata,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic          bus_rmw,
  input  logic          bus_bit_we,
  input  logic [SW-1:0] bus_bit_sel,
  input  logic          bus_bit_val,
  output logic [W-1:0]  rd_data,
  input  logic          pull_en,
  input  logic [W-1:0]  ovr_mask,
  input  logic [W-1:0]  ovr_oe,
  input  logic [W-1:0]  ovr_out,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_pu
);
  localparam logic [1:0] A_LATCH = 2'd0;
  localparam logic [1:0] A_INMD  = 2'd1;
  localparam logic [1:0] A_OUTMD = 2'd2;

  logic [W-1:0] latch_q, inmode_q, outmode_q;
  logic [W-1:0] sync1_q, sync2_q;
  logic [W-1:0] lat_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
    end else if (bus_we && bus_addr == A_LATCH) begin
      latch_q <= bus_wdata;
    end else if (bus_bit_we) begin
      latch_q[bus_bit_sel] <= bus_bit_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inmode_q  <= '1;
      outmode_q <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_INMD)  inmode_q  <= bus_wdata;
      if (bus_addr == A_OUTMD) outmode_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    rd_data = '0;
    if (bus_re) begin
      unique case (bus_addr)
        A_LATCH: rd_data = bus_rmw ? latch_q : (sync2_q & inmode_q);
        A_INMD:  rd_data = inmode_q;
        A_OUTMD: rd_data = outmode_q;
        default: rd_data = '0;
      endcase
    end
  end

  assign lat_oe  = ~latch_q | outmode_q;
  assign pad_oe  = inmode_q & ((ovr_mask & ovr_oe) | (~ovr_mask & lat_oe));
  assign pad_out = (ovr_mask & ovr_out) | (~ovr_mask & latch_q);
  assign pad_pu  = inmode_q & {W{pull_en}} & ~(pad_oe & ~pad_out);
endmodule

module gpio_port_regs_chk #(
  parameter int W = 8,
  localparam int SW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    bus_addr,
  input logic [W-1:0]  bus_wdata,
  input logic          bus_we,
  input logic          bus_re,
  input logic          bus_rmw,
  input logic          bus_bit_we,
  input logic [SW-1:0] bus_bit_sel,
  input logic          bus_bit_val,
  input logic [W-1:0]  rd_data,
  input logic [W-1:0]  latch_q,
  input logic [W-1:0]  inmode_q,
  input logic [W-1:0]  pad_oe,
  input logic [W-1:0]  pad_out,
  input logic [W-1:0]  pad_pu
);
  a_r2_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == 2'd0 |=> latch_q == $past(bus_wdata));

  a_r2_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we && !bus_bit_we |=> $stable(latch_q));

  a_r7_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    bus_bit_we && !(bus_we && bus_addr == 2'd0) |=>
      latch_q[$past(bus_bit_sel)] == $past(bus_bit_val) &&
      $countones(latch_q ^ $past(latch_q)) <= 1);

  a_r4_rmw_latch: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && bus_rmw && bus_addr == 2'd0 |-> rd_data == latch_q);

  a_r5_analog_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | pad_pu) & ~inmode_q) == '0);

  a_r8_no_pull_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe & ~pad_out) == '0);
endmodule

bind gpio_port_regs gpio_port_regs_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_re(bus_re), .bus_rmw(bus_rmw),
  .bus_bit_we(bus_bit_we), .bus_bit_sel(bus_bit_sel), .bus_bit_val(bus_bit_val),
  .rd_data(rd_data), .latch_q(latch_q), .inmode_q(inmode_q),
  .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
);

// File: tb/tb_gpio_port_regs.sv
module tb_gpio_port_regs;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic       bus_we = 0, bus_re = 0, bus_rmw = 0, bus_bit_we = 0, bus_bit_val = 0;
  logic [2:0] bus_bit_sel = 0;
  logic [7:0] rd_data;
  logic       pull_en = 0;
  logic [7:0] ovr_mask = 0, ovr_oe = 0, ovr_out = 0;
  logic [7:0] pin_in = 8'hA5;
  logic [7:0] pad_oe, pad_out, pad_pu;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_port_regs dut (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic bitop(logic [2:0] s, logic v, logic also_byte, logic [7:0] d);
    @(negedge clk);
    bus_bit_we = 1; bus_bit_sel = s; bus_bit_val = v;
    bus_addr = 0; bus_wdata = d; bus_we = also_byte;
    @(negedge clk);
    bus_bit_we = 0; bus_we = 0;
  endtask

  task automatic rd(logic [1:0] a, logic rmw, output logic [7:0] d);
    bus_addr = a; bus_rmw = rmw; bus_re = 1;
    #1 d = rd_data;
    bus_re = 0; bus_rmw = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    @(negedge clk);
    rd(2'd0, 1, d); check("R1 latch", d, 8'hFF);
    rd(2'd1, 0, d); check("R1 inmode", d, 8'hFF);
    rd(2'd2, 0, d); check("R1 outmode", d, 8'h00);
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R10 idle rd_data", rd_data, 8'h00);
    rd(2'd3, 0, d); check("R10 addr3", d, 8'h00);
  endtask

  task automatic t_pin_latency();
    logic [7:0] d;
    @(negedge clk);
    rd(2'd0, 0, d); check("R3 settled pins", d, 8'hA5);
    pin_in = 8'h3C;
    @(negedge clk);
    rd(2'd0, 0, d); check("R3 one edge", d, 8'hA5);
    @(negedge clk);
    rd(2'd0, 0, d); check("R3 two edges", d, 8'h3C);
  endtask

  task automatic t_rmw_split();
    logic [7:0] d;
    wr(2'd0, 8'h5A);
    rd(2'd0, 0, d); check("R3 pin read", d, 8'h3C);
    rd(2'd0, 1, d); check("R4 rmw read", d, 8'h5A);
    @(negedge clk); @(negedge clk);
    rd(2'd0, 1, d); check("R2 latch held", d, 8'h5A);
  endtask

  task automatic t_drive();
    logic [7:0] d;
    wr(2'd2, 8'h0F);
    rd(2'd2, 0, d); check("R10 outmode read", d, 8'h0F);
    check("R6 pad_oe", pad_oe, 8'hAF);
    check("R6 driven value", pad_out & pad_oe, 8'h0A);
  endtask

  task automatic t_pullup();
    @(negedge clk);
    pull_en = 1;
    #1 check("R8 pull-up on", pad_pu, 8'h5A);
    pull_en = 0;
    #1 check("R8 pull-up off", pad_pu, 8'h00);
    pull_en = 1;
  endtask

  task automatic t_analog();
    logic [7:0] d;
    wr(2'd1, 8'hF0);
    rd(2'd1, 0, d); check("R2 inmode write", d, 8'hF0);
    rd(2'd0, 0, d); check("R5 analog reads zero", d, 8'h30);
    check("R5 analog oe", pad_oe, 8'hA0);
    check("R5 analog pu", pad_pu, 8'h50);
    wr(2'd1, 8'hFF);
  endtask

  task automatic t_bitops();
    logic [7:0] d;
    bitop(3'd0, 1, 0, 8'h00);
    rd(2'd0, 1, d); check("R7 set bit0", d, 8'h5B);
    bitop(3'd6, 0, 0, 8'h00);
    rd(2'd0, 1, d); check("R7 clear bit6", d, 8'h1B);
    bitop(3'd7, 1, 1, 8'h00);
    rd(2'd0, 1, d); check("R7 byte wins", d, 8'h00);
    wr(2'd0, 8'h1B);
  endtask

  task automatic t_override();
    logic [7:0] d;
    @(negedge clk);
    ovr_mask = 8'h0F; ovr_oe = 8'h03; ovr_out = 8'h01;
    #1 check("R9 override oe", pad_oe, 8'hE3);
    check("R9 override out", pad_out, 8'h11);
    wr(2'd0, 8'hFF);
    rd(2'd0, 1, d); check("R9 latch updated", d, 8'hFF);
    check("R9 override oe after write", pad_oe, 8'h03);
    ovr_mask = 8'h00;
    #1 check("R9 released", pad_oe, 8'h0F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_pin_latency();
    t_rmw_split();
    t_drive();
    t_pullup();
    t_analog();
    t_bitops();
    t_override();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule